// File: doc/BRIEF.md
# Systolic Three-Tap FIR Convolver

This block computes a sliding dot product over a stream of signed samples. Result `y_i` equals `w1*x_i + w2*x_(i+1) + w3*x_(i+2)`: three consecutive samples, each multiplied by its own weight. Samples enter a linear chain of cells and move one cell per accepted sample. Every cell therefore works on every sample without fetching it again. Each cell contains a weight store, a registered multiplier and a registered adder. The multiply of one window overlaps the addition of the previous window. Partial sums pass from cell to cell with a skew that keeps each window aligned.

Every cell holds several weight banks. A bank select that travels with each sample chooses the bank for that sample's result. This lets the filter change coefficients on the fly without a pipeline flush. Weights are written one at a time through a load port that addresses a bank and a tap. A gap in the input stream freezes the sample chain, so results do not depend on the spacing between samples.

Top module: `fir_systolic`

## Requirements
- R1: Once the window is full, each result equals `w[b][0]*x_i + w[b][1]*x_(i+1) + w[b][2]*x_(i+2)`. Here `x_(i+2)` is the newest accepted sample, tap index 0 holds w1 (the weight of the oldest sample in the window) and `b` is the bank in effect.
- R2: After reset, the first NTAPS-1 accepted samples produce no result. Every later accepted sample produces exactly one result.
- R3: `res_valid` is high for one cycle exactly NTAPS+1 rising edges after the edge that accepted the newest sample of the window. With the default of three taps this is 4 edges.
- R4: While `smp_valid` is low, the sample chain and the partial sums hold. A stream with gaps gives the same result values, in the same order, as a back-to-back stream.
- R5: `smp_bank` is captured together with each accepted sample. Each result uses the bank captured with its newest sample, so switching banks between consecutive samples takes effect on the very next result.
- R6: A rising edge with `wl_en` high writes `wl_data` into bank `wl_bank`, tap `wl_tap`. The write takes effect for products formed after that edge, and reset clears all weights to zero.
- R7: The result is held at full precision, 34 bits signed by default. Three products of -32768 by -32768 give 3221225472.
- R8: During reset and after it, until the first result, `res_valid` is 0 and `res_data` is 0.
- R9: A back-to-back stream yields one result per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe; the sample and bank are accepted when high |
| smp_data | input | SMP_W (16) | Signed input sample |
| smp_bank | input | BANK_W (2) | Weight bank to use for this sample's result |
| wl_en | input | 1 | Weight write strobe |
| wl_bank | input | BANK_W (2) | Bank addressed by the write |
| wl_tap | input | TAP_W (2) | Tap addressed by the write (0 is w1) |
| wl_data | input | COEF_W (16) | Signed weight value |
| res_valid | output | 1 | Result strobe |
| res_data | output | ACC_W (34) | Signed full-precision result |

## Verification
A weight in the wrong bank or tap, or a sample chain that shifts during a gap, changes the value of the very next result that uses it. A fault in the product skew delays or mixes in a product from another window, and the result value is off on the first result after the window fills. A fault in the fill counter or in the valid tag shows up as a missing or extra `res_valid` pulse. Such a pulse, or one in the wrong cycle, is seen in the NTAPS+1 edges after the sample that caused it.

// File: rtl/fir_sys_pkg.sv
package fir_sys_pkg;
  localparam int DEF_SMP_W  = 16;
  localparam int DEF_COEF_W = 16;
  localparam int DEF_TAPS   = 3;
  localparam int DEF_BANKS  = 4;

  // index width that never collapses to zero bits
  function automatic int idx_width(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/fir_fill_ctl.sv
module fir_fill_ctl #(
  parameter int NTAPS  = 3,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BANK_W-1:0] in_bank,
  output logic [BANK_W-1:0] bank_q,
  output logic              mul_en,
  output logic              prod_valid,
  output logic              full
);
  localparam int FILL_W = fir_sys_pkg::idx_width(NTAPS);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(NTAPS - 1);

  logic [FILL_W-1:0] fill_q, fill_d;
  logic [BANK_W-1:0] bank_d;
  logic              mul_d;

  always_comb begin
    fill_d = fill_q;
    bank_d = bank_q;
    mul_d  = 1'b0;
    if (in_valid) begin
      bank_d = in_bank;
      mul_d  = (fill_q == FILL_MAX);
      if (fill_q != FILL_MAX) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q     <= '0;
      bank_q     <= '0;
      mul_en     <= 1'b0;
      prod_valid <= 1'b0;
    end else begin
      fill_q     <= fill_d;
      bank_q     <= bank_d;
      mul_en     <= mul_d;
      prod_valid <= mul_en;
    end
  end

  assign full = (fill_q == FILL_MAX);

  // R2
  mul_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_en |-> $past(in_valid));
  // R2
  fill_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(in_valid));
endmodule

// File: rtl/fir_cell.sv
module fir_cell #(
  parameter int SMP_W   = 16,
  parameter int COEF_W  = 16,
  parameter int ACC_W   = 34,
  parameter int NBANKS  = 4,
  parameter int BANK_W  = 2,
  parameter int TAP_W   = 2,
  parameter int TAP_IDX = 0,
  parameter int SKEW    = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic signed [SMP_W-1:0] smp_in,
  output logic signed [SMP_W-1:0] smp_out,
  input  logic                    wl_en,
  input  logic [BANK_W-1:0]       wl_bank,
  input  logic [TAP_W-1:0]        wl_tap,
  input  logic signed [COEF_W-1:0] wl_data,
  input  logic [BANK_W-1:0]       bank_sel,
  input  logic                    mul_en,
  input  logic signed [ACC_W-1:0] sum_in,
  input  logic                    sum_vin,
  output logic signed [ACC_W-1:0] sum_out,
  output logic                    sum_vout
);
  localparam int PROD_W = SMP_W + COEF_W;

  logic signed [SMP_W-1:0]  smp_q, smp_d;
  logic signed [COEF_W-1:0] w_q [NBANKS];
  logic signed [COEF_W-1:0] w_d [NBANKS];
  logic signed [PROD_W-1:0] prod_q, prod_d, prod_al;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic                     vout_q;
  logic                     tap_hit;

  assign tap_hit = wl_en && (wl_tap == TAP_W'(TAP_IDX));

  // sample stage and weight store
  always_comb begin
    smp_d = smp_en ? smp_in : smp_q;
    for (int b = 0; b < NBANKS; b++) begin
      w_d[b] = (tap_hit && (wl_bank == BANK_W'(b))) ? wl_data : w_q[b];
    end
  end

  // multiply stage
  always_comb begin
    prod_d = prod_q;
    if (mul_en) prod_d = PROD_W'(smp_q) * PROD_W'(w_q[bank_sel]);
  end

  // add stage
  always_comb begin
    acc_d = acc_q;
    if (sum_vin) acc_d = sum_in + ACC_W'(prod_al);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= '0;
      prod_q <= '0;
      acc_q  <= '0;
      vout_q <= 1'b0;
      for (int b = 0; b < NBANKS; b++) w_q[b] <= '0;
    end else begin
      smp_q  <= smp_d;
      prod_q <= prod_d;
      acc_q  <= acc_d;
      vout_q <= sum_vin;
      for (int b = 0; b < NBANKS; b++) w_q[b] <= w_d[b];
    end
  end

  // product alignment: cell k adds k cycles after the multiply
  generate
    if (SKEW == 0) begin : g_noskew
      assign prod_al = prod_q;
    end else begin : g_skew
      logic signed [PROD_W-1:0] sk_q [SKEW];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < SKEW; i++) sk_q[i] <= '0;
        end else begin
          sk_q[0] <= prod_q;
          for (int i = 1; i < SKEW; i++) sk_q[i] <= sk_q[i-1];
        end
      end
      assign prod_al = sk_q[SKEW-1];
    end
  endgenerate

  assign smp_out  = smp_q;
  assign sum_out  = acc_q;
  assign sum_vout = vout_q;

  // R4
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(smp_out));
  // R4
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_vin |=> $stable(sum_out));
  // R6
  wload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tap_hit |=> (w_q[$past(wl_bank)] == $past(wl_data)));
endmodule

// File: rtl/fir_systolic.sv
module fir_systolic #(
  parameter int SMP_W  = fir_sys_pkg::DEF_SMP_W,
  parameter int COEF_W = fir_sys_pkg::DEF_COEF_W,
  parameter int NTAPS  = fir_sys_pkg::DEF_TAPS,
  parameter int NBANKS = fir_sys_pkg::DEF_BANKS,
  localparam int BANK_W = fir_sys_pkg::idx_width(NBANKS),
  localparam int TAP_W  = fir_sys_pkg::idx_width(NTAPS),
  localparam int ACC_W  = SMP_W + COEF_W + $clog2(NTAPS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [SMP_W-1:0]  smp_data,
  input  logic [BANK_W-1:0]        smp_bank,
  input  logic                     wl_en,
  input  logic [BANK_W-1:0]        wl_bank,
  input  logic [TAP_W-1:0]         wl_tap,
  input  logic signed [COEF_W-1:0] wl_data,
  output logic                     res_valid,
  output logic signed [ACC_W-1:0]  res_data
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [BANK_W-1:0] bank_q;
  logic              mul_en, prod_valid, full;

  fir_fill_ctl #(.NTAPS(NTAPS), .BANK_W(BANK_W)) u_ctl (
    .clk(clk), .rst_n(rst_sync), .in_valid(smp_valid), .in_bank(smp_bank),
    .bank_q(bank_q), .mul_en(mul_en), .prod_valid(prod_valid), .full(full)
  );

  logic signed [SMP_W-1:0] smp_chain [NTAPS+1];
  logic signed [ACC_W-1:0] sum_chain [NTAPS+1];
  logic                    v_chain   [NTAPS+1];

  assign smp_chain[0] = smp_data;
  assign sum_chain[0] = '0;
  assign v_chain[0]   = prod_valid;

  // cell k holds the newest-but-k sample, so it carries tap NTAPS-1-k
  generate
    for (genvar k = 0; k < NTAPS; k++) begin : g_cell
      fir_cell #(
        .SMP_W(SMP_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .NBANKS(NBANKS),
        .BANK_W(BANK_W), .TAP_W(TAP_W), .TAP_IDX(NTAPS-1-k), .SKEW(k)
      ) u_cell (
        .clk(clk), .rst_n(rst_sync),
        .smp_en(smp_valid), .smp_in(smp_chain[k]), .smp_out(smp_chain[k+1]),
        .wl_en(wl_en), .wl_bank(wl_bank), .wl_tap(wl_tap), .wl_data(wl_data),
        .bank_sel(bank_q), .mul_en(mul_en),
        .sum_in(sum_chain[k]), .sum_vin(v_chain[k]),
        .sum_out(sum_chain[k+1]), .sum_vout(v_chain[k+1])
      );
    end
  endgenerate

  assign res_valid = v_chain[NTAPS];
  assign res_data  = sum_chain[NTAPS];

  // R2
  out_full_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    res_valid |-> full);
  // R8
  rst_idle_chk: assert property (@(posedge clk)
    !rst_sync |-> (!res_valid && (res_data == '0)));
endmodule

// File: tb/fir_systolic_test.sv
module fir_systolic_test;
  localparam int CLK_PERIOD = 10;
  localparam int SMP_W  = 16;
  localparam int COEF_W = 16;
  localparam int NTAPS  = 3;
  localparam int NBANKS = 4;
  localparam int ACC_W  = 34;
  localparam int QN     = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [SMP_W-1:0] smp_data = '0;
  logic [1:0] smp_bank = '0;
  logic wl_en = 1'b0;
  logic [1:0] wl_bank = '0;
  logic [1:0] wl_tap = '0;
  logic signed [COEF_W-1:0] wl_data = '0;
  logic res_valid;
  logic signed [ACC_W-1:0] res_data;

  fir_systolic uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .smp_bank(smp_bank), .wl_en(wl_en), .wl_bank(wl_bank), .wl_tap(wl_tap),
    .wl_data(wl_data), .res_valid(res_valid), .res_data(res_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int out_seen = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint w_m [NBANKS][NTAPS];
  longint hist [NTAPS];
  int     hist_n = 0;
  longint exp_y [QN];
  int     exp_due [QN];
  string  exp_tag [QN];
  int     q_head = 0;
  int     q_tail = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // output monitor: timing and value against the model queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_valid) begin
        out_seen++;
        if (q_head == q_tail) begin
          check(1'b0, "R2 spurious result", longint'(res_data), 0);
        end else begin
          check(exp_due[q_head] == cyc, {exp_tag[q_head], " R3 latency"}, cyc, exp_due[q_head]);
          check(longint'(res_data) == exp_y[q_head], exp_tag[q_head], longint'(res_data), exp_y[q_head]);
          q_head++;
        end
      end else if (q_head != q_tail && exp_due[q_head] <= cyc) begin
        check(1'b0, {exp_tag[q_head], " R3 missing result"}, 0, 1);
        q_head++;
      end
    end
  end

  task automatic load_w(input int b, input int t, input longint v);
    wl_en = 1'b1; wl_bank = 2'(b); wl_tap = 2'(t); wl_data = COEF_W'(v);
    w_m[b][t] = longint'($signed(COEF_W'(v)));
    @(negedge clk);
    wl_en = 1'b0;
  endtask

  task automatic beat(input longint s, input int b, input string tag);
    longint y;
    smp_valid = 1'b1; smp_data = SMP_W'(s); smp_bank = 2'(b);
    for (int k = 0; k < NTAPS-1; k++) hist[k] = hist[k+1];
    hist[NTAPS-1] = longint'($signed(SMP_W'(s)));
    if (hist_n < NTAPS) hist_n++;
    if (hist_n == NTAPS) begin
      y = 0;
      for (int k = 0; k < NTAPS; k++) y += w_m[b][k] * hist[k];
      exp_y[q_tail] = y;
      exp_due[q_tail] = cyc + NTAPS + 2;
      exp_tag[q_tail] = tag;
      q_tail++;
    end
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    smp_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic longint rnd16();
    return longint'($signed(16'($urandom)));
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2718));
    for (int b = 0; b < NBANKS; b++)
      for (int t = 0; t < NTAPS; t++) w_m[b][t] = 0;
    for (int k = 0; k < NTAPS; k++) hist[k] = 0;

    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R8 valid in reset", res_valid, 0);
    check(res_data == '0, "R8 data in reset", res_data, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(res_valid == 1'b0, "R8 valid after reset", res_valid, 0);
    check(res_data == '0, "R8 data after reset", res_data, 0);

    // directed: weights 1,2,3; samples 1..5 give 14, 20, 26
    load_w(0, 0, 1); load_w(0, 1, 2); load_w(0, 2, 3);
    idle(2);
    beat(1, 0, "R2 fill");
    beat(2, 0, "R2 fill");
    idle(10);
    check(out_seen == 0, "R2 no result before window full", out_seen, 0);
    beat(3, 0, "R1 directed y1");
    beat(4, 0, "R1 directed y2");
    beat(5, 0, "R1 directed y3 R9");
    idle(10);
    check(out_seen == 3, "R1 directed result count", out_seen, 3);

    // R6: load random banks 1 and 2, extremes in bank 3
    for (int t = 0; t < NTAPS; t++) begin
      load_w(1, t, rnd16());
      load_w(2, t, rnd16());
      load_w(3, t, -32768);
    end
    idle(4);

    // R9: continuous random stream
    for (int i = 0; i < 40; i++) beat(rnd16(), 1, "R9 back-to-back");
    idle(10);

    // R4: gapped random stream
    for (int i = 0; i < 60; i++) begin
      beat(rnd16(), 2, "R4 gapped");
      idle(int'($urandom_range(0, 3)));
    end
    idle(10);

    // R5: bank changes on every sample
    for (int i = 0; i < 50; i++) begin
      beat(rnd16(), int'($urandom_range(0, 2)), "R5 bank switch");
      if ($urandom_range(0, 1) == 1) idle(1);
    end
    idle(10);

    // R7: full-scale extremes
    for (int i = 0; i < 4; i++) beat(-32768, 3, "R7 extreme negative");
    for (int i = 0; i < 3; i++) beat(32767, 3, "R7 extreme positive");
    beat(-32768, 3, "R7 extreme mixed");
    idle(10);

    // R6: overwrite one tap of bank 3 and reuse the bank
    load_w(3, 1, 32767);
    idle(2);
    for (int i = 0; i < 20; i++) beat(rnd16(), 3, "R6 rewritten weight");
    idle(12);

    check(q_head == q_tail, "R2 all expected results delivered", q_tail - q_head, 0);
    finish_run();
  end
endmodule